// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel words into frames on one serial line that rests high. A word is written into a one-entry holding register. When the line is free, the word is copied into a shift register and sent. Each frame has a low start bit, then the data bits with the least significant bit first, then one high stop bit. Bit timing comes from an external oversample tick, and every bit lasts a fixed number of those ticks. Because of the holding register, software can supply the next word while the current one is still on the wire, so frames can follow each other with no gap.

Two flags report progress. The empty flag means the holding register can take another word. The done flag means the last stop bit has fully left the line. Each flag has its own interrupt enable, and the interrupt output is the OR of the two enabled flags. A mode input selects the longer or shorter data field. An optional parity bit replaces the top data bit and can be even or odd. A break request sends an all-low frame in place of data.

Top module: `async_tx_top`

## Requirements
- R1: After reset, `serOut` is 1, `txEmpty` is 1, `txDone` is 1 and `irq` is 0 (both interrupt enables low).
- R2: While `txEnable` is 0, no frame starts: `serOut` stays 1 and a written word is held. It is sent once `txEnable` rises.
- R3: A frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. The data field has `DATA_MAX` bits when `longWord` is 1 and `DATA_MAX`-1 bits when it is 0.
- R4: With `parityEn` at 1, the top bit of the data field is replaced by a parity bit. With `parityOdd` at 0 this makes the number of ones in the data field even; with `parityOdd` at 1 it makes that number odd.
- R5: A write clears `txEmpty`. The word is taken into the shift register when the next frame starts: at once if the line is idle, otherwise when the current stop bit ends. `txEmpty` reads 1 again in the cycle after it is taken.
- R6: A write while `txEmpty` is 0 is ignored. The held word is unchanged and no extra frame is sent.
- R7: `txDone` is cleared when a frame starts. It sets only when a stop bit ends and nothing is waiting to be sent. It stays 0 between back-to-back frames.
- R8: A pulse on `breakReq` sends a frame whose start bit and data field are all 0, followed by a 1 stop bit. A pending break is sent before a pending data word.
- R9: `irq` is 1 exactly when (`txEmpty` and `txeIe`) or (`txDone` and `tcIe`) is true.
- R10: Bit boundaries occur only on cycles where `osTick` is 1, and each bit lasts `OVS_RATIO` ticks. With no ticks, the line holds its current bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| osTick | input | 1 | Oversample tick, one clock wide |
| txEnable | input | 1 | Allows frames to start |
| longWord | input | 1 | 1 selects the long data field |
| parityEn | input | 1 | Enables the parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| breakReq | input | 1 | Pulse that requests a break frame |
| wrValid | input | 1 | Write strobe for the holding register |
| wrData | input | DATA_MAX | Word to send |
| txeIe | input | 1 | Interrupt enable for the empty flag |
| tcIe | input | 1 | Interrupt enable for the done flag |
| serOut | output | 1 | Serial line, idle high |
| txEmpty | output | 1 | Holding register is empty |
| txDone | output | 1 | Last frame has fully left the line |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `OVS_RATIO` set to 8 and `DATA_MAX` at its default of 9, and it drives a tick on every second clock. One bit therefore takes 16 clocks and an 11-bit frame stays under 200 clocks. This makes it affordable to run dozens of random frames across every combination of word length and parity, as well as back-to-back frames, a break queued behind data, writes to a full register, and a long stretch with the tick stopped. The bench samples the line in the middle of each bit, so any error in bit order, parity value or frame length shows up directly in the decoded bits.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } txState_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic capture;  // take wrData into the holding register
    logic load;     // build a frame into the shift register
    logic brkSel;   // the frame being loaded is a break
    logic shift;    // advance to the next bit
    logic busy;     // a frame is on the line
  } txStrobes_t;

endpackage

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int OVS_RATIO = 16,
  parameter int DATA_MAX  = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       osTick,
  input  logic       txEnable,
  input  logic       longWord,
  input  logic       breakReq,
  input  logic       wrValid,
  input  logic       txeIe,
  input  logic       tcIe,
  output txStrobes_t strb,
  output logic       txEmpty,
  output logic       txDone,
  output logic       irq
);

  localparam int FRAME_MAX = DATA_MAX + 2;
  localparam int SUB_W     = (OVS_RATIO > 1) ? $clog2(OVS_RATIO) : 1;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);
  localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(OVS_RATIO - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(FRAME_MAX - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(FRAME_MAX - 2);

  txState_e        stateQ;
  logic [SUB_W-1:0] subCntQ;
  logic [CNT_W-1:0] bitCntQ;
  logic            fullQ;
  logic            brkPendQ;
  logic            doneQ;
  logic            lenQ;

  logic haveWork;
  logic bitEnd;
  logic lastBit;
  logic frameEnd;
  logic startNow;

  assign haveWork = txEnable && (brkPendQ || fullQ);
  assign bitEnd   = (stateQ == TX_SEND) && osTick && (subCntQ == SUB_LAST);
  assign lastBit  = (bitCntQ == (lenQ ? LAST_LONG : LAST_SHORT));
  assign frameEnd = bitEnd && lastBit;
  assign startNow = haveWork && ((stateQ == TX_IDLE) || frameEnd);

  always_comb begin
    strb         = '0;
    strb.capture = wrValid && !fullQ;
    strb.load    = startNow;
    strb.brkSel  = startNow && brkPendQ;
    strb.shift   = bitEnd && !startNow;
    strb.busy    = (stateQ == TX_SEND);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= TX_IDLE;
      subCntQ  <= '0;
      bitCntQ  <= '0;
      fullQ    <= 1'b0;
      brkPendQ <= 1'b0;
      doneQ    <= 1'b1;
      lenQ     <= 1'b0;
    end else begin
      if (strb.capture) fullQ <= 1'b1;
      if (breakReq)     brkPendQ <= 1'b1;

      if (startNow) begin
        stateQ  <= TX_SEND;
        subCntQ <= '0;
        bitCntQ <= '0;
        doneQ   <= 1'b0;
        lenQ    <= longWord;
        if (brkPendQ) brkPendQ <= breakReq;
        else          fullQ    <= 1'b0;
      end else if (stateQ == TX_SEND && osTick) begin
        if (subCntQ == SUB_LAST) begin
          subCntQ <= '0;
          if (lastBit) begin
            stateQ <= TX_IDLE;
            doneQ  <= 1'b1;
          end else begin
            bitCntQ <= bitCntQ + 1'b1;
          end
        end else begin
          subCntQ <= subCntQ + 1'b1;
        end
      end
    end
  end

  assign txEmpty = !fullQ;
  assign txDone  = doneQ;
  assign irq     = (txEmpty && txeIe) || (txDone && tcIe);

  // A frame never starts while the transmitter is disabled
  p_load_enabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> txEnable);

  // Starting a frame clears the done flag
  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !txDone);

  // Taking a data word frees the holding register
  p_empty_after_take_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.brkSel) |=> txEmpty);

  // Bits advance only on oversample ticks
  p_shift_on_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |-> osTick);

  // With both flags low the interrupt stays low
  p_quiet_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!txEmpty && !txDone) |-> !irq);

endmodule

// File: rtl/async_tx_datapath.sv
module async_tx_datapath
  import async_tx_pkg::*;
#(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobes_t          strb,
  input  logic [DATA_MAX-1:0] wrData,
  input  logic                longWord,
  input  logic                parityEn,
  input  logic                parityOdd,
  output logic                serOut
);

  localparam int FRAME_MAX = DATA_MAX + 2;

  logic [DATA_MAX-1:0]  dataQ;
  logic [FRAME_MAX-1:0] shiftQ;
  logic [DATA_MAX-1:0]  word;
  logic [FRAME_MAX-1:0] frame;
  logic                 lowParity;
  int                   nBits;

  always_comb begin
    nBits = longWord ? DATA_MAX : DATA_MAX - 1;
    word  = dataQ;
    if (!longWord) word[DATA_MAX-1] = 1'b0;
    lowParity = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < nBits - 1) lowParity = lowParity ^ word[i];
    end
    if (parityEn) word[nBits-1] = lowParity ^ parityOdd;
    if (strb.brkSel) word = '0;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < nBits) frame[i+1] = word[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      shiftQ <= '1;
    end else begin
      if (strb.capture) dataQ <= wrData;
      if (strb.load)       shiftQ <= frame;
      else if (strb.shift) shiftQ <= {1'b1, shiftQ[FRAME_MAX-1:1]};
    end
  end

  assign serOut = shiftQ[0];

  // A captured word is held exactly as written
  p_capture_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (dataQ == $past(wrData)));

  // An idle line rests high
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busy |-> serOut);

endmodule

// File: rtl/async_tx_top.sv
module async_tx_top
  import async_tx_pkg::*;
#(
  parameter int OVS_RATIO = 16,
  parameter int DATA_MAX  = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                osTick,
  input  logic                txEnable,
  input  logic                longWord,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                breakReq,
  input  logic                wrValid,
  input  logic [DATA_MAX-1:0] wrData,
  input  logic                txeIe,
  input  logic                tcIe,
  output logic                serOut,
  output logic                txEmpty,
  output logic                txDone,
  output logic                irq
);

  txStrobes_t strb;

  async_tx_ctrl #(.OVS_RATIO(OVS_RATIO), .DATA_MAX(DATA_MAX)) ctrl_i (
    .clk(clk), .rstN(rstN), .osTick(osTick), .txEnable(txEnable),
    .longWord(longWord), .breakReq(breakReq), .wrValid(wrValid),
    .txeIe(txeIe), .tcIe(tcIe), .strb(strb), .txEmpty(txEmpty),
    .txDone(txDone), .irq(irq)
  );

  async_tx_datapath #(.DATA_MAX(DATA_MAX)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .longWord(longWord), .parityEn(parityEn), .parityOdd(parityOdd),
    .serOut(serOut)
  );

endmodule

// File: tb/async_tx_top_tb_top.sv
module async_tx_top_tb_top;

  localparam int OVS  = 8;
  localparam int DMAX = 9;
  localparam int BITC = OVS * 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic osTick = 1'b0;
  logic tickOn = 1'b1;
  logic tickPh = 1'b0;
  logic txEnable = 1'b0, longWord = 1'b0, parityEn = 1'b0, parityOdd = 1'b0;
  logic breakReq = 1'b0, wrValid = 1'b0, txeIe = 1'b0, tcIe = 1'b0;
  logic [DMAX-1:0] wrData = '0;
  logic serOut, txEmpty, txDone, irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tickPh <= ~tickPh;
    osTick <= tickOn & ~tickPh;
  end

  async_tx_top #(.OVS_RATIO(OVS), .DATA_MAX(DMAX)) dut_i (
    .clk(clk), .rstN(rstN), .osTick(osTick), .txEnable(txEnable),
    .longWord(longWord), .parityEn(parityEn), .parityOdd(parityOdd),
    .breakReq(breakReq), .wrValid(wrValid), .wrData(wrData),
    .txeIe(txeIe), .tcIe(tcIe), .serOut(serOut), .txEmpty(txEmpty),
    .txDone(txDone), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DMAX-1:0] expField(input logic [DMAX-1:0] d, input bit w9,
                                               input bit pe, input bit po, input bit brk);
    int nb = w9 ? DMAX : DMAX - 1;
    logic [DMAX-1:0] f = '0;
    logic p = 1'b0;
    for (int i = 0; i < nb; i++) f[i] = d[i];
    if (pe) begin
      for (int i = 0; i < nb - 1; i++) p ^= d[i];
      f[nb-1] = p ^ po;
    end
    if (brk) f = '0;
    return f;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeWord(input logic [DMAX-1:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic pulseBreak();
    @(negedge clk);
    breakReq = 1'b1;
    @(negedge clk);
    breakReq = 1'b0;
  endtask

  // Decode one frame at mid-bit sample points
  task automatic readFrame(input int nb, input string req, output logic [DMAX-1:0] f,
                           output bit ok);
    int t = 0;
    f = '0;
    ok = 1'b1;
    while (serOut !== 1'b0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 4000) begin
      chk(0, {req, " no start bit"}, 0, 1);
      ok = 1'b0;
      return;
    end
    cyc(BITC / 2 - 1);
    if (serOut !== 1'b0) ok = 1'b0;
    for (int i = 0; i < nb; i++) begin
      cyc(BITC);
      f[i] = serOut;
    end
    cyc(BITC);
    if (serOut !== 1'b1) ok = 1'b0;
  endtask

  task automatic sendCheck(input logic [DMAX-1:0] d, input bit w9, input bit pe,
                           input bit po, input string req);
    logic [DMAX-1:0] got, exp;
    bit ok;
    longWord = w9;
    parityEn = pe;
    parityOdd = po;
    writeWord(d);
    readFrame(w9 ? DMAX : DMAX - 1, req, got, ok);
    exp = expField(d, w9, pe, po, 1'b0);
    chk(ok && got == exp, req, int'(got), int'(exp));
  endtask

  initial begin
    logic [DMAX-1:0] got, exp;
    bit ok;
    int lows;
    void'($urandom(32'h5eed_0042));

    cyc(4);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(serOut === 1'b1 && txEmpty === 1'b1 && txDone === 1'b1 && irq === 1'b0,
        "R1", {serOut, txEmpty, txDone, irq}, 4'b1110);

    // R2: disabled holds the word; R6: a second write while full is ignored
    writeWord(9'h0A5);
    writeWord(9'h05A);
    lows = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (serOut !== 1'b1) lows++;
    end
    chk(lows == 0 && txEmpty === 1'b0, "R2 disabled", lows, 0);
    txEnable = 1'b1;
    readFrame(DMAX - 1, "R2", got, ok);
    chk(ok && got == 9'h0A5, "R6 held word kept", int'(got), 9'h0A5);
    lows = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (serOut !== 1'b1) lows++;
    end
    chk(lows == 0, "R6 no extra frame", lows, 0);
    chk(txDone === 1'b1 && txEmpty === 1'b1, "R7 done after frame", {txDone, txEmpty}, 2'b11);

    // R9 interrupt enables
    txeIe = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R9 empty irq", irq, 1);
    txeIe = 1'b0; tcIe = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R9 done irq", irq, 1);
    tcIe = 1'b0;
    @(negedge clk);
    chk(irq === 1'b0, "R9 masked", irq, 0);

    // R5 flag timing on an idle line
    longWord = 1'b0; parityEn = 1'b0;
    @(negedge clk);
    wrValid = 1'b1; wrData = 9'h081;
    @(negedge clk);
    wrValid = 1'b0;
    chk(txEmpty === 1'b0 && serOut === 1'b1, "R5 write clears empty", txEmpty, 0);
    @(negedge clk);
    chk(txEmpty === 1'b1 && serOut === 1'b0 && txDone === 1'b0, "R5 taken next cycle",
        {txEmpty, serOut, txDone}, 3'b100);
    readFrame(DMAX - 1, "R5", got, ok);
    chk(ok && got == 9'h081, "R3 LSB first", int'(got), 9'h081);
    cyc(BITC);

    // R5/R7 back-to-back frames with a word queued behind the current one
    longWord = 1'b1;
    writeWord(9'h1C3);
    cyc(3);
    writeWord(9'h03C);
    chk(txEmpty === 1'b0, "R5 waits for frame end", txEmpty, 0);
    readFrame(DMAX, "R5", got, ok);
    chk(ok && got == 9'h1C3, "R3 long word", int'(got), 9'h1C3);
    chk(txDone === 1'b0, "R7 stays low between frames", txDone, 0);
    readFrame(DMAX, "R5", got, ok);
    chk(ok && got == 9'h03C, "R5 second frame", int'(got), 9'h03C);
    cyc(BITC);
    chk(txDone === 1'b1 && txEmpty === 1'b1, "R7 done at end", {txDone, txEmpty}, 2'b11);

    // R8 break queued with data behind a running frame
    longWord = 1'b0;
    writeWord(9'h0FF);
    cyc(3);
    writeWord(9'h055);
    pulseBreak();
    readFrame(DMAX - 1, "R8", got, ok);
    chk(ok && got == 9'h0FF, "R8 first frame", int'(got), 9'h0FF);
    readFrame(DMAX - 1, "R8", got, ok);
    chk(ok && got == 9'h000, "R8 break frame", int'(got), 0);
    readFrame(DMAX - 1, "R8", got, ok);
    chk(ok && got == 9'h055, "R8 data after break", int'(got), 9'h055);
    cyc(BITC);

    // R10 no ticks: the line holds its bit
    tickOn = 1'b0;
    writeWord(9'h0F0);
    cyc(100);
    chk(serOut === 1'b0 && txDone === 1'b0, "R10 frozen", serOut, 0);
    tickOn = 1'b1;
    readFrame(DMAX - 1, "R10", got, ok);
    chk(ok && got == 9'h0F0, "R10 resumes", int'(got), 9'h0F0);
    cyc(BITC);

    // R4 directed parity cases
    sendCheck(9'h007, 1'b0, 1'b1, 1'b0, "R4 even 8");
    sendCheck(9'h007, 1'b0, 1'b1, 1'b1, "R4 odd 8");
    sendCheck(9'h0FF, 1'b1, 1'b1, 1'b0, "R4 even 9");
    cyc(BITC);

    // R3 R4 random mix
    for (int k = 0; k < 40; k++) begin
      logic [DMAX-1:0] d = DMAX'($urandom);
      logic [2:0] c = 3'($urandom);
      sendCheck(d, c[0], c[1], c[2], "R3 R4 random");
      cyc(BITC);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule